// File: doc/BRIEF.md
# Serially Configured Four-Input Lookup Cell

This block is one programmable logic cell for a gate-array fabric. Its function comes from sixteen configuration bits, one for each truth-table row. A four-level tree of two-input multiplexers, steered by the four user inputs, selects the bit for the current row. Because the table holds one bit per row, the cell can realise any Boolean function of four inputs. A user flip-flop can register the selected bit. One mode bit chooses between the registered output and the combinational output.

Configuration travels as a serial bitstream on its own clock. `cfg_en` works as the valid qualifier for each `cfg_din` bit. The cell accepts a bit on every rising `cfg_clk` edge while `cfg_en` is high and never applies back-pressure, so there is no ready signal. The tail of the shift chain drives `cfg_dout`, which lets cells be daisy-chained. Once loaded, the cell keeps its function with no further configuration traffic. While `cfg_en` is high the output reads 0, so a half-loaded table is never seen by the fabric. `cfg_en` must be stable around user-clock edges.

Top module: `prog_lut_cell`

## Requirements
- R1: After a reset (rst high, sampled on a rising edge of both clk and cfg_clk), all sixteen table bits and the mode bit are 0. `y` then reads 0 for every input pattern and `cfg_dout` reads 0. This holds even if a function had been loaded before the reset.
- R2: On each rising cfg_clk edge with cfg_en high, the 17-bit chain shifts by one and takes in `cfg_din`. A full load is 17 bits in this order: table row 15 first, down to row 0, then the mode bit last (0 = combinational, 1 = registered).
- R3: `cfg_dout` shows the bit at the far end of the chain. After a full load it shows row 15, and each further shift brings out the next bit in the order row 15 … row 0, then mode.
- R4: Rising cfg_clk edges with cfg_en low leave the chain and the loaded function unchanged, whatever `cfg_din` is.
- R5: In combinational mode, `y` equals table row {lut_in[3], lut_in[2], lut_in[1], lut_in[0]} (lut_in[3] is the most significant select, and pattern 0000 picks row 0). It follows input changes within the same cycle.
- R6: In registered mode, `y` shows the table bit selected by the inputs present at the previous rising clk edge. A change of input does not reach `y` until the next rising clk edge.
- R7: While cfg_en is high, `y` is 0 and the user flip-flop is held at 0. After cfg_en falls, a registered-mode `y` stays 0 until the next rising clk edge.
- R8: A new load completely replaces the previous function. The cell realises AND, XOR, majority and constant-one functions exactly as their truth tables give.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | User clock for the output flip-flop |
| rst | input | 1 | Synchronous active-high reset, seen in both clock domains |
| cfg_clk | input | 1 | Configuration shift clock |
| cfg_en | input | 1 | Configuration bit valid / shift enable |
| cfg_din | input | 1 | Serial configuration data in |
| cfg_dout | output | 1 | Serial configuration data out (chain tail) |
| lut_in | input | 4 | Logic inputs; bit 3 is the most significant row-select bit |
| y | output | 1 | Cell output |

## Verification
Two things can fall in the same user-clock cycle in registered mode: a reconfiguration starting, and the flip-flop capturing the lookup result. The bench loads constant-one in registered mode and lets `y` settle high. It then raises cfg_en between clock edges and checks that `y` drops at once. After cfg_en falls, `y` must stay 0 until the next clk edge and return to 1 one edge later. This shows that the forced reset took priority over the capture and left no stale registered value.

// File: rtl/plc_pkg.sv
`timescale 1ns/1ps
package plc_pkg;
  localparam int unsigned LUT_K = 4;
  localparam int unsigned LUT_ROWS = 1 << LUT_K;
  localparam int unsigned CHAIN_LEN = LUT_ROWS + 1;

  typedef enum logic {
    OUT_COMB = 1'b0,
    OUT_REG  = 1'b1
  } out_mode_e;
endpackage

// File: rtl/plc_cfg_chain.sv
`timescale 1ns/1ps
// Serial configuration shift chain. The newest bit enters at index 0;
// the oldest bit sits at the top index and forms the daisy-chain tail.
module plc_cfg_chain #(
  parameter int unsigned LEN = 17
) (
  input  logic           cfg_clk,
  input  logic           rst,
  input  logic           cfg_en,
  input  logic           cfg_din,
  output logic [LEN-1:0] chain
);
  always_ff @(posedge cfg_clk) begin
    if (rst) begin
      chain <= '0;
    end else if (cfg_en) begin
      chain <= {chain[LEN-2:0], cfg_din};
    end
  end
endmodule

// File: rtl/plc_mux2.sv
`timescale 1ns/1ps
module plc_mux2 (
  input  logic d0,
  input  logic d1,
  input  logic s,
  output logic y
);
  assign y = s ? d1 : d0;
endmodule

// File: rtl/plc_mux_tree.sv
`timescale 1ns/1ps
// Heap-indexed multiplexer tree: node 1 is the root, leaves sit at
// ROWS..2*ROWS-1. A node at depth d is steered by select bit K-1-d.
module plc_mux_tree #(
  parameter int unsigned K = 4,
  localparam int unsigned ROWS = 1 << K
) (
  input  logic [ROWS-1:0] leaves,
  input  logic [K-1:0]    idx,
  output logic            y
);
  logic [2*ROWS-1:1] node;

  for (genvar r = 0; r < ROWS; r++) begin : g_leaf
    assign node[ROWS+r] = leaves[r];
  end

  for (genvar d = 0; d < K; d++) begin : g_level
    for (genvar j = 0; j < (1 << d); j++) begin : g_node
      localparam int unsigned I = (1 << d) + j;
      plc_mux2 u_mux (
        .d0 (node[2*I]),
        .d1 (node[2*I+1]),
        .s  (idx[K-1-d]),
        .y  (node[I])
      );
    end
  end

  assign y = node[1];
endmodule

// File: rtl/plc_out_stage.sv
`timescale 1ns/1ps
// Output flip-flop plus mode select; configuration forces the output low.
module plc_out_stage (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_en,
  input  logic               lut_y,
  input  plc_pkg::out_mode_e mode,
  output logic               y
);
  logic q;

  always_ff @(posedge clk) begin
    if (rst || cfg_en) begin
      q <= 1'b0;
    end else begin
      q <= lut_y;
    end
  end

  always_comb begin
    if (cfg_en) begin
      y = 1'b0;
    end else if (mode == plc_pkg::OUT_REG) begin
      y = q;
    end else begin
      y = lut_y;
    end
  end
endmodule

// File: rtl/prog_lut_cell.sv
`timescale 1ns/1ps
module prog_lut_cell #(
  parameter int unsigned K = plc_pkg::LUT_K,
  localparam int unsigned ROWS = 1 << K,
  localparam int unsigned LEN = ROWS + 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cfg_clk,
  input  logic         cfg_en,
  input  logic         cfg_din,
  output logic         cfg_dout,
  input  logic [K-1:0] lut_in,
  output logic         y
);
  logic [LEN-1:0]     chain;
  logic [ROWS-1:0]    table_bits;
  plc_pkg::out_mode_e mode;
  logic               lut_y;

  plc_cfg_chain #(.LEN(LEN)) u_chain (
    .cfg_clk (cfg_clk),
    .rst     (rst),
    .cfg_en  (cfg_en),
    .cfg_din (cfg_din),
    .chain   (chain)
  );

  // Row r lives at chain[r+1]; the mode bit, shifted last, at chain[0].
  assign table_bits = chain[LEN-1:1];
  assign mode       = plc_pkg::out_mode_e'(chain[0]);
  assign cfg_dout   = chain[LEN-1];

  plc_mux_tree #(.K(K)) u_tree (
    .leaves (table_bits),
    .idx    (lut_in),
    .y      (lut_y)
  );

  plc_out_stage u_out (
    .clk    (clk),
    .rst    (rst),
    .cfg_en (cfg_en),
    .lut_y  (lut_y),
    .mode   (mode),
    .y      (y)
  );
endmodule

// File: rtl/plc_checker.sv
`timescale 1ns/1ps
module plc_checker #(
  parameter int unsigned LEN = 17
) (
  input logic           clk,
  input logic           cfg_clk,
  input logic           rst,
  input logic           cfg_en,
  input logic           cfg_din,
  input logic           cfg_dout,
  input logic [LEN-1:0] chain,
  input logic           mode_bit,
  input logic           lut_y,
  input logic           y
);
  // R2: enabled edges shift the chain and take in the serial bit
  a_r2_shift_in: assert property (@(posedge cfg_clk) disable iff (rst)
    cfg_en |=> chain == {$past(chain[LEN-2:0]), $past(cfg_din)});

  // R3: the tail pin follows the bit one place below it
  a_r3_tail_out: assert property (@(posedge cfg_clk) disable iff (rst)
    cfg_en |=> cfg_dout == $past(chain[LEN-2]));

  // R4: disabled edges leave the chain unchanged
  a_r4_hold_chain: assert property (@(posedge cfg_clk) disable iff (rst)
    !cfg_en |=> $stable(chain));

  // R7: output low throughout configuration
  a_r7_forced_low: assert property (@(posedge clk) disable iff (rst)
    cfg_en |-> y == 1'b0);

  // R5: combinational mode shows the tree result directly
  a_r5_comb_path: assert property (@(posedge clk) disable iff (rst)
    (!cfg_en && !mode_bit) |-> y == lut_y);

  // R6: registered mode shows the tree result one clk edge late
  a_r6_reg_latency: assert property (@(posedge clk) disable iff (rst)
    (!cfg_en && mode_bit && !$past(cfg_en) && !$past(rst)) |-> y == $past(lut_y));
endmodule

bind prog_lut_cell plc_checker #(.LEN(LEN)) u_plc_checker (
  .clk      (clk),
  .cfg_clk  (cfg_clk),
  .rst      (rst),
  .cfg_en   (cfg_en),
  .cfg_din  (cfg_din),
  .cfg_dout (cfg_dout),
  .chain    (chain),
  .mode_bit (chain[0]),
  .lut_y    (lut_y),
  .y        (y)
);

// File: tb/test_prog_lut_cell.sv
`timescale 1ns/1ps
module test_prog_lut_cell;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_clk = 1'b0;
  logic       cfg_en = 1'b0;
  logic       cfg_din = 1'b0;
  logic       cfg_dout;
  logic [3:0] lut_in = 4'd0;
  logic       y;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  prog_lut_cell i_prog_lut_cell (
    .clk      (clk),
    .rst      (rst),
    .cfg_clk  (cfg_clk),
    .cfg_en   (cfg_en),
    .cfg_din  (cfg_din),
    .cfg_dout (cfg_dout),
    .lut_in   (lut_in),
    .y        (y)
  );

  task automatic check(input bit ok, input string req, input logic act, input logic exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s at %0t: actual=%b expected=%b", req, $time, act, exp);
    end
  endtask

  function automatic logic [15:0] tt_and4();
    return 16'h8000;
  endfunction

  function automatic logic [15:0] tt_xor4();
    logic [15:0] t;
    for (int r = 0; r < 16; r++) t[r] = ^r[3:0];
    return t;
  endfunction

  function automatic logic [15:0] tt_major();
    logic [15:0] t;
    for (int r = 0; r < 16; r++) t[r] = ($countones(r[3:0]) >= 3);
    return t;
  endfunction

  task automatic pulse_cfg(input logic b);
    cfg_din = b;
    #1 cfg_clk = 1'b1;
    #1 cfg_clk = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    cfg_en = 1'b0;
    pulse_cfg(1'b1);
    pulse_cfg(1'b1);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic load_cfg(input logic [15:0] tt, input logic m);
    @(negedge clk);
    cfg_en = 1'b1;
    #1 check(y == 1'b0, "R7 output low during load", y, 1'b0);
    for (int r = 15; r >= 0; r--) pulse_cfg(tt[r]);
    pulse_cfg(m);
    @(negedge clk);
    cfg_en = 1'b0;
  endtask

  task automatic sweep_comb(input logic [15:0] tt, input string req);
    for (int r = 0; r < 16; r++) begin
      lut_in = r[3:0];
      #1 check(y == tt[r], req, y, tt[r]);
    end
  endtask

  task automatic sweep_reg(input logic [15:0] tt, input string req);
    for (int r = 0; r < 16; r++) begin
      @(negedge clk);
      lut_in = r[3:0];
      #1;
      if (r > 0) check(y == tt[r-1], "R6 latency hold", y, tt[r-1]);
      @(posedge clk);
      #1 check(y == tt[r], req, y, tt[r]);
    end
  endtask

  task automatic t_reset_state();
    load_cfg(16'hFFFF, 1'b0);
    do_reset();
    check(cfg_dout == 1'b0, "R1 chain tail after reset", cfg_dout, 1'b0);
    sweep_comb(16'h0000, "R1 constant zero after reset");
  endtask

  task automatic t_functions();
    load_cfg(tt_and4(), 1'b0);
    sweep_comb(tt_and4(), "R5 AND4 comb");
    load_cfg(tt_and4(), 1'b1);
    sweep_reg(tt_and4(), "R6 AND4 reg");
    load_cfg(tt_xor4(), 1'b0);
    sweep_comb(tt_xor4(), "R8 XOR4 over AND4 comb");
    load_cfg(tt_xor4(), 1'b1);
    sweep_reg(tt_xor4(), "R6 XOR4 reg");
    load_cfg(tt_major(), 1'b0);
    sweep_comb(tt_major(), "R5 majority comb");
    load_cfg(tt_major(), 1'b1);
    sweep_reg(tt_major(), "R6 majority reg");
    load_cfg(16'hFFFF, 1'b0);
    sweep_comb(16'hFFFF, "R8 const1 comb");
    load_cfg(16'hFFFF, 1'b1);
    sweep_reg(16'hFFFF, "R6 const1 reg");
  endtask

  task automatic t_hold_chain();
    load_cfg(tt_major(), 1'b0);
    for (int k = 0; k < 20; k++) pulse_cfg(k[0]);
    sweep_comb(tt_major(), "R4 disabled shifts ignored");
  endtask

  task automatic t_daisy();
    logic [15:0] tt;
    logic exp;
    tt = 16'hA53C;
    load_cfg(tt, 1'b1);
    @(negedge clk);
    cfg_en = 1'b1;
    for (int k = 0; k < 17; k++) begin
      exp = (k < 16) ? tt[15-k] : 1'b1;
      #0.1 check(cfg_dout == exp, "R3 R2 tail order", cfg_dout, exp);
      pulse_cfg(1'b0);
    end
    @(negedge clk);
    cfg_en = 1'b0;
    sweep_comb(16'h0000, "R2 chain flushed to zero");
  endtask

  task automatic t_cfg_vs_capture();
    load_cfg(16'hFFFF, 1'b1);
    lut_in = 4'd5;
    repeat (2) @(posedge clk);
    #1 check(y == 1'b1, "R6 const1 settled", y, 1'b1);
    @(negedge clk);
    cfg_en = 1'b1;
    #1 check(y == 1'b0, "R7 forced low on enable", y, 1'b0);
    @(posedge clk);
    @(negedge clk);
    cfg_en = 1'b0;
    #1 check(y == 1'b0, "R7 flop cleared after enable", y, 1'b0);
    @(posedge clk);
    #1 check(y == 1'b1, "R7 capture resumes", y, 1'b1);
  endtask

  initial begin
    do_reset();
    check(y == 1'b0, "R1 output after reset", y, 1'b0);
    check(cfg_dout == 1'b0, "R1 tail after reset", cfg_dout, 1'b0);
    t_functions();
    t_hold_chain();
    t_daisy();
    t_cfg_vs_capture();
    t_reset_state();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule